// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the per-processor front end of an interrupt controller. A processor reads its acknowledge register to claim the best pending interrupt and writes its end-of-interrupt register to finish one. The block tracks which interrupt is running and at what priority. Interrupts that were preempted are kept as a nested chain. Each entry of an ID-indexed link table holds the ID and priority that were running when that ID was claimed.

The distributor supplies the highest-pending ID and its priority. It also supplies two per-ID flag vectors. One says whether an interrupt is claimed for all processors (one-of-N model). The other says whether an interrupt is level-triggered, enabled, still asserted and aimed at this processor. The block returns single-cycle requests to clear a pending bit and to mark an interrupt pending again. A completion may name any member of the nested chain. A non-running member is found by walking the chain and is unlinked out of order, and the bus is stalled through a busy flag while the walk runs.

Top module: `ackc_tracker`

## Requirements
- R1: After reset the enable bit is 0, the priority mask is 0xF0, the running priority reads 0x100 and no interrupt is running.
- R2: Register offsets are 0x00 enable, 0x04 priority mask, 0x0C acknowledge (read), 0x10 end-of-interrupt (write), 0x14 running priority, 0x18 highest pending. The enable register keeps only bit 0 and the mask keeps only bits [7:0]. Any other read returns 0.
- R3: Offset 0x18 returns the supplied ID when enabled, when the ID is not 1023 and when its priority is at or below the mask value; otherwise it returns 1023.
- R4: An acknowledge read returns 1023 and changes nothing when offset 0x18 would give 1023 or when the pending priority is not strictly lower than the running priority.
- R5: A successful acknowledge returns the ID and makes it the running ID with its priority. It pulses a clear request carrying that ID one cycle after the read is accepted. The all-processors flag of that request equals the ID's one-of-N bit.
- R6: An end-of-interrupt write takes its ID from bits [9:0]. It is ignored (no pulse, no stall, no state change) when that ID is not below NUM_IRQ, and also when nothing is running.
- R7: Completing the running ID restores the ID and priority that it preempted, and the priority is 0x100 when nothing remains. The bus stalls for 1 cycle.
- R8: Completing a chain member at depth j (running = depth 0) unlinks it, leaves the running ID unchanged and stalls for j+1 cycles.
- R9: Completing an ID that is absent from a chain of n entries changes nothing and stalls for n cycles.
- R10: Every accepted end-of-interrupt pulses a re-pend request for its ID when that ID's level-hold bit is set.
- R11: The interrupt output is high one cycle after enable, a valid highest-pending ID and a pending priority strictly below the running priority hold together.
- R12: A request is taken only while busy is low. Read data comes with a one-cycle valid pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register offset |
| wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Chain update in progress; requests are held off |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 32 | Read data |
| hp_id_i | input | 10 | Highest-pending ID from the distributor, 1023 = none |
| hp_prio_i | input | PRIO_W | Priority of hp_id_i |
| one_of_n_i | input | NUM_IRQ | Per-ID one-of-N claim model |
| lvl_hold_i | input | NUM_IRQ | Per-ID level-held, enabled and targeted here |
| irq_o | output | 1 | Interrupt request to the processor |
| clr_valid_o | output | 1 | Clear-pending request pulse |
| clr_id_o | output | 10 | ID to clear |
| clr_all_o | output | 1 | Clear for all processors |
| rpnd_valid_o | output | 1 | Re-pend request pulse |
| rpnd_id_o | output | 10 | ID to re-pend |

## Verification
Read data, clear and re-pend pulses all appear in the first cycle after a request is accepted, and the bench samples them at the falling edge that follows that acceptance edge. Busy then stays high for a count the model derives from the completed ID's depth in its queue: 1 for the running ID, j+1 for a deeper member and the chain length for an absent ID. The bench checks busy at each of those falling edges and at the first idle one. The interrupt output is registered from state that settles only at the end of a stall, so it is compared one idle cycle later still, against the model's enable, mask and running-priority condition.

// File: rtl/ackc_pkg.sv
package ackc_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = '1;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PMASK = 8'h04;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_EOI   = 8'h10;
  localparam logic [7:0] OFS_RPRI  = 8'h14;
  localparam logic [7:0] OFS_HPEND = 8'h18;

  typedef enum logic [1:0] {ST_IDLE, ST_POP, ST_WALK, ST_SPLICE} walk_st_e;
endpackage

// File: rtl/ackc_link_ram.sv
module ackc_link_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 19,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ackc_select.sv
module ackc_select
  import ackc_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              en,
  input  logic [ID_W-1:0]   hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W:0]   run_prio,
  output logic [ID_W-1:0]   cur_id,
  output logic              take
);
  always_comb begin
    cur_id = (en && hp_id != ID_NONE && hp_prio <= pmask) ? hp_id : ID_NONE;
    take   = (cur_id != ID_NONE) && ({1'b0, hp_prio} < run_prio);
  end
endmodule

// File: rtl/ackc_tracker.sv
module ackc_tracker
  import ackc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned AW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic               busy_o,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o,
  input  logic [ID_W-1:0]    hp_id_i,
  input  logic [PRIO_W-1:0]  hp_prio_i,
  input  logic [NUM_IRQ-1:0] one_of_n_i,
  input  logic [NUM_IRQ-1:0] lvl_hold_i,
  output logic               irq_o,
  output logic               clr_valid_o,
  output logic [ID_W-1:0]    clr_id_o,
  output logic               clr_all_o,
  output logic               rpnd_valid_o,
  output logic [ID_W-1:0]    rpnd_id_o
);
  localparam int unsigned IX_W = $clog2(NUM_IRQ);
  localparam int unsigned LW   = ID_W + PRIO_W + 1;
  localparam logic [PRIO_W:0]   RP_NONE   = (PRIO_W+1)'(1 << PRIO_W);
  localparam logic [PRIO_W-1:0] PMASK_RST = PRIO_W'(8'hF0);
  localparam logic [ID_W-1:0]   ID_LIMIT  = ID_W'(NUM_IRQ);
  localparam logic [IX_W:0]     STEP_MAX  = (IX_W+1)'(NUM_IRQ - 1);

  walk_st_e          st_q;
  logic              ctrl_q;
  logic [PRIO_W-1:0] pmask_q;
  logic [ID_W-1:0]   run_id_q, cur_q, eid_q;
  logic [PRIO_W:0]   run_prio_q;
  logic [IX_W:0]     steps_q;

  logic              ram_we;
  logic [IX_W-1:0]   ram_wa, ram_ra;
  logic [LW-1:0]     ram_wd, rd_q;
  logic [ID_W-1:0]   rd_id;
  logic [PRIO_W:0]   rd_pri;
  logic [ID_W-1:0]   cur_id;
  logic              take, accept, eoi_ok, ack_hit;
  logic [ID_W-1:0]   eoi_id;
  logic              unused_wbits;

  assign rd_id        = rd_q[ID_W-1:0];
  assign rd_pri       = rd_q[LW-1:ID_W];
  assign busy_o       = (st_q != ST_IDLE);
  assign accept       = req_i && (st_q == ST_IDLE);
  assign eoi_id       = wdata_i[ID_W-1:0];
  assign unused_wbits = ^wdata_i[31:ID_W];
  assign eoi_ok       = accept && we_i && (addr_i == AW'(OFS_EOI)) &&
                        (eoi_id < ID_LIMIT) && (run_id_q != ID_NONE);
  assign ack_hit      = accept && !we_i && (addr_i == AW'(OFS_ACK)) && take;

  ackc_select #(.PRIO_W(PRIO_W)) u_sel (
    .en(ctrl_q), .hp_id(hp_id_i), .hp_prio(hp_prio_i), .pmask(pmask_q),
    .run_prio(run_prio_q), .cur_id(cur_id), .take(take)
  );

  ackc_link_ram #(.DEPTH(NUM_IRQ), .DW(LW)) u_link (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(ram_ra), .rdata(rd_q)
  );

  // Link table port steering: push on acknowledge, follow/splice during a walk
  always_comb begin
    ram_we = 1'b0;
    ram_wa = cur_id[IX_W-1:0];
    ram_wd = {run_prio_q, run_id_q};
    ram_ra = run_id_q[IX_W-1:0];
    unique case (st_q)
      ST_IDLE:   ram_we = ack_hit;
      ST_WALK:   ram_ra = (rd_id == eid_q) ? eid_q[IX_W-1:0] : rd_id[IX_W-1:0];
      ST_SPLICE: begin
        ram_we = 1'b1;
        ram_wa = cur_q[IX_W-1:0];
        ram_wd = rd_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      ctrl_q       <= 1'b0;
      pmask_q      <= PMASK_RST;
      run_id_q     <= ID_NONE;
      run_prio_q   <= RP_NONE;
      cur_q        <= ID_NONE;
      eid_q        <= ID_NONE;
      steps_q      <= '0;
      rvalid_o     <= 1'b0;
      rdata_o      <= '0;
      irq_o        <= 1'b0;
      clr_valid_o  <= 1'b0;
      clr_id_o     <= ID_NONE;
      clr_all_o    <= 1'b0;
      rpnd_valid_o <= 1'b0;
      rpnd_id_o    <= ID_NONE;
    end else begin
      rvalid_o     <= 1'b0;
      clr_valid_o  <= 1'b0;
      rpnd_valid_o <= 1'b0;
      irq_o        <= take;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (!we_i) begin
            rvalid_o <= 1'b1;
            unique case (addr_i)
              AW'(OFS_CTRL):  rdata_o <= {31'b0, ctrl_q};
              AW'(OFS_PMASK): rdata_o <= 32'(pmask_q);
              AW'(OFS_RPRI):  rdata_o <= 32'(run_prio_q);
              AW'(OFS_HPEND): rdata_o <= 32'(cur_id);
              AW'(OFS_ACK): begin
                rdata_o <= take ? 32'(cur_id) : 32'(ID_NONE);
                if (take) begin
                  run_id_q    <= cur_id;
                  run_prio_q  <= {1'b0, hp_prio_i};
                  clr_valid_o <= 1'b1;
                  clr_id_o    <= cur_id;
                  clr_all_o   <= one_of_n_i[cur_id[IX_W-1:0]];
                end
              end
              default: rdata_o <= '0;
            endcase
          end else begin
            unique case (addr_i)
              AW'(OFS_CTRL):  ctrl_q  <= wdata_i[0];
              AW'(OFS_PMASK): pmask_q <= wdata_i[PRIO_W-1:0];
              AW'(OFS_EOI): if (eoi_ok) begin
                rpnd_valid_o <= lvl_hold_i[eoi_id[IX_W-1:0]];
                rpnd_id_o    <= eoi_id;
                eid_q        <= eoi_id;
                cur_q        <= run_id_q;
                steps_q      <= '0;
                st_q         <= (eoi_id == run_id_q) ? ST_POP : ST_WALK;
              end
              default: ;
            endcase
          end
        end
        ST_POP: begin
          run_id_q   <= rd_id;
          run_prio_q <= rd_pri;
          st_q       <= ST_IDLE;
        end
        ST_WALK: begin
          steps_q <= steps_q + 1'b1;
          if (rd_id == ID_NONE || steps_q == STEP_MAX) st_q <= ST_IDLE;
          else if (rd_id == eid_q)                     st_q <= ST_SPLICE;
          else                                         cur_q <= rd_id;
        end
        ST_SPLICE: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  AST_CLR_MATCHES_READ: assert property (@(posedge clk) disable iff (rst)
    clr_valid_o |-> (rvalid_o && rdata_o == 32'(clr_id_o))); // R5
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
    (run_id_q == ID_NONE) |-> (run_prio_q == RP_NONE)); // R7
  AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WALK) |=> (run_id_q == $past(run_id_q))); // R8
  AST_RPND_FROM_EOI: assert property (@(posedge clk) disable iff (rst)
    rpnd_valid_o |-> $past(req_i && we_i && !busy_o)); // R10
  AST_BUSY_NO_RDATA: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !rvalid_o); // R12
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(clr_valid_o && rpnd_valid_o)); // R6
endmodule

// File: tb/tb_ackc_tracker.sv
`timescale 1ns/1ps
module tb_ackc_tracker;
  localparam int NIRQ = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic busy, rvalid, irq, clr_v, clr_all, rp_v;
  logic [31:0] rdata;
  logic [9:0] hp_id = 10'd1023, clr_id, rp_id;
  logic [7:0] hp_prio = '0;
  logic [NIRQ-1:0] one_of_n = '0, lvl_hold = '0;

  int nvec = 0, nerr = 0;
  int qid[$];
  int qpr[$];
  int ctrl_m = 0, pmask_m = 'hF0;

  always #2 clk = ~clk;

  ackc_tracker #(.NUM_IRQ(NIRQ), .PRIO_W(8), .AW(8)) dut (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .hp_id_i(hp_id), .hp_prio_i(hp_prio), .one_of_n_i(one_of_n), .lvl_hold_i(lvl_hold),
    .irq_o(irq), .clr_valid_o(clr_v), .clr_id_o(clr_id), .clr_all_o(clr_all),
    .rpnd_valid_o(rp_v), .rpnd_id_o(rp_id)
  );

  function automatic int cur_m();
    return (ctrl_m != 0 && hp_id != 10'd1023 && int'(hp_prio) <= pmask_m) ? int'(hp_id) : 1023;
  endfunction
  function automatic int runp_m();
    return (qpr.size() > 0) ? qpr[0] : 256;
  endfunction
  function automatic int take_m();
    return (cur_m() != 1023 && int'(hp_prio) < runp_m()) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xact(input bit w, input int a, input int d, input string tag);
    int e_rd = 0, e_clr = 0, e_cid = 0, e_call = 0, e_rp = 0, e_rpid = 0, bcnt = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = 8'(a); wdata = 32'(d);
    if (!w) begin
      case (a)
        'h00: e_rd = ctrl_m;
        'h04: e_rd = pmask_m;
        'h14: e_rd = runp_m();
        'h18: e_rd = cur_m();
        'h0C: if (take_m() != 0) begin
          e_rd = cur_m(); e_clr = 1; e_cid = e_rd; e_call = int'(one_of_n[e_rd]);
          qid.push_front(e_rd); qpr.push_front(int'(hp_prio));
        end else e_rd = 1023;
        default: e_rd = 0;
      endcase
    end else begin
      case (a)
        'h00: ctrl_m = d & 1;
        'h04: pmask_m = d & 'hFF;
        'h10: begin
          int e = d & 'h3FF;
          if (e < NIRQ && qid.size() > 0) begin
            int j = -1;
            if (lvl_hold[e]) begin e_rp = 1; e_rpid = e; end
            foreach (qid[i]) if (qid[i] == e && j < 0) j = i;
            if (j == 0) begin bcnt = 1; void'(qid.pop_front()); void'(qpr.pop_front()); end
            else if (j > 0) begin bcnt = j + 1; qid.delete(j); qpr.delete(j); end
            else bcnt = qid.size();
          end
        end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    req = 1'b0;
    @(negedge clk);
    chk({tag, " rvalid"}, int'(rvalid), w ? 0 : 1);
    if (!w) chk({tag, " rdata"}, int'(rdata), e_rd);
    chk({tag, " clr_valid"}, int'(clr_v), e_clr);
    if (e_clr != 0) begin
      chk({tag, " clr_id"}, int'(clr_id), e_cid);
      chk({tag, " clr_all"}, int'(clr_all), e_call);
    end
    chk({tag, " rpnd_valid"}, int'(rp_v), e_rp);
    if (e_rp != 0) chk({tag, " rpnd_id"}, int'(rp_id), e_rpid);
    chk({tag, " busy"}, int'(busy), (bcnt > 0) ? 1 : 0);
    for (int k = 1; k < bcnt; k++) begin
      @(negedge clk);
      chk({tag, " busy hold"}, int'(busy), 1);
    end
    @(negedge clk);
    chk({tag, " busy end"}, int'(busy), 0);
    @(negedge clk);
    chk({tag, " irq R11"}, int'(irq), take_m());
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 busy after reset", int'(busy), 0);
    xact(0, 'h00, 0, "R1 ctrl");
    xact(0, 'h04, 0, "R1 pmask");
    xact(0, 'h14, 0, "R1 run prio");
    xact(0, 'h18, 0, "R1 hpend");
    xact(0, 'h0C, 0, "R4 ack idle");
    xact(0, 'h20, 0, "R2 unmapped");
    xact(1, 'h00, 'hFFFF_FFFE, "R2 ctrl bit0");
    xact(0, 'h00, 0, "R2 ctrl read");
    xact(1, 'h00, 1, "R2 ctrl set");
    xact(0, 'h00, 0, "R2 ctrl read1");
    xact(1, 'h04, 'h1AB, "R2 pmask wr");
    xact(0, 'h04, 0, "R2 pmask rd");
    hp_id = 10'd5; hp_prio = 8'h80;
    xact(1, 'h04, 'h70, "R3 mask low");
    xact(0, 'h18, 0, "R3 masked");
    xact(0, 'h0C, 0, "R4 masked ack");
    xact(1, 'h04, 'hFF, "R3 mask open");
    xact(0, 'h18, 0, "R3 visible");
    xact(0, 'h0C, 0, "R5 ack 5");
    xact(0, 'h0C, 0, "R4 same prio");
    hp_id = 10'd9; hp_prio = 8'h40; one_of_n[9] = 1'b1;
    xact(0, 'h0C, 0, "R5 ack 9 all");
    hp_id = 10'd12; hp_prio = 8'h20;
    xact(0, 'h0C, 0, "R5 ack 12");
    xact(0, 'h14, 0, "R5 run prio");
    hp_id = 10'd20; hp_prio = 8'h10;
    xact(0, 'h18, 0, "R11 pending above");
    hp_id = 10'd1023;
    lvl_hold[9] = 1'b1;
    xact(1, 'h10, 9, "R8 R10 eoi middle");
    xact(0, 'h14, 0, "R8 run unchanged");
    xact(1, 'h10, 33, "R9 eoi absent");
    xact(1, 'h10, 1023, "R6 eoi spurious");
    xact(1, 'h10, 'hFC00_0064, "R6 eoi range");
    xact(1, 'h10, 12, "R7 eoi running");
    xact(0, 'h14, 0, "R7 restored prio");
    lvl_hold[5] = 1'b1;
    xact(1, 'h10, 5, "R7 R10 eoi last");
    xact(0, 'h14, 0, "R7 idle prio");
    xact(1, 'h10, 5, "R6 eoi nothing running");
    for (int i = 0; i < 6; i++) begin
      hp_id = 10'(40 + i); hp_prio = 8'(8'h60 - 8'h10 * i);
      xact(0, 'h0C, 0, "R5 deep ack");
    end
    hp_id = 10'd1023;
    xact(1, 'h10, 40, "R8 eoi bottom");
    xact(1, 'h10, 42, "R8 eoi inner");
    xact(1, 'h10, 45, "R7 eoi top");
    xact(0, 'h14, 0, "R7 top restored");
    xact(1, 'h10, 44, "R7 eoi next");
    xact(1, 'h10, 41, "R8 eoi inner2");
    xact(0, 'h14, 0, "R8 prio after");
    xact(1, 'h10, 43, "R7 eoi final");
    xact(0, 'h0C, 0, "R4 ack none");
    hp_id = 10'd7; hp_prio = 8'h01;
    xact(0, 'h18, 0, "R3 R11 enabled");
    xact(1, 'h00, 0, "R2 disable");
    xact(0, 'h18, 0, "R3 disabled");
    xact(0, 'h0C, 0, "R4 disabled ack");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule